// File: doc/BRIEF.md
# SD Card Clock Generator with Revision-Dependent Divider

This block makes the clock for an SD/SDIO card interface. It picks one of two reference clocks: a fixed bus clock, or a PLL clock. It can stop the result, and it divides it by an even ratio taken from a small table. A software-visible control word holds three fields: a source-select bit, a run bit and a 3-bit ratio code. The clock path runs in a fixed order. The source is chosen first, the gate acts on the chosen clock, and the divider acts on the gated clock.

The ratio table depends on the silicon revision, which is read from a chip identification word. Early parts divide by 16 on the top code. Later parts use the same code to pass the chosen source straight through, so a card clock equal to the bus clock becomes possible. Changes to the source or the ratio are applied only at the end of a whole output period. The source switch itself is glitch-free, so the card never sees a shortened pulse. Besides the clock, the block gives a one-cycle enable pulse in the source clock domain for each output period. This pulse is handy for simulation and for logic that works from clock enables.

Top module: `sdclk_gen`

## Requirements
- R1: After a synchronous reset the control word reads 0, `sd_clk` stays low and `sd_clk_en` stays low. The block then uses the bus clock, has the gate off and ratio code 0.
- R2: A write stores bit 31 as the run bit, bits 30:28 as the ratio code and bit 8 as the source select. `rd_data` returns exactly these bits, with every other bit 0, one `clk_bus` cycle after the write.
- R3: Source select 0 times the output from `clk_bus`, and source select 1 times it from `clk_pll`.
- R4: Codes 0 to 6 divide the chosen source by 2, 4, 6, 8, 10, 12 and 14. The output is high for exactly half of each period, and each period starts with its low half.
- R5: When `chip_id[23:16]` is below 2, code 7 divides by 16.
- R6: When `chip_id[23:16]` is 2 or more, code 7 passes the chosen source through undivided, with the source's own high and low times.
- R7: With the run bit clear, `sd_clk` is held low, `sd_clk_en` is held low and the divider count is cleared.
- R8: While running, `sd_clk_en` is high for exactly one source cycle per output period, starting at the rising edge of `sd_clk`. In pass-through mode it is therefore high on every source cycle.
- R9: A change of ratio code while running takes effect only after the current output period has ended. No high or low phase is shorter than the shortest legal phase of either setting.
- R10: Switching sources while running never enables both sources onto the internal clock at once. It produces no output pulse shorter than one phase of the settings in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus reference clock (source 0); also clocks the control register |
| clk_pll | input | 1 | PLL reference clock (source 1) |
| rst | input | 1 | Synchronous active-high reset, held for several cycles of both clocks |
| wr_en | input | 1 | Control word write strobe, sampled on `clk_bus` |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control word (implemented bits only) |
| chip_id | input | 32 | Chip identification word; bits 23:16 carry the revision |
| sd_clk | output | 1 | Gated, divided card clock |
| sd_clk_en | output | 1 | One-source-cycle pulse per output period |

## Verification
A control word is readable one `clk_bus` cycle after its write. The bench drives each write on a falling edge and reads `rd_data` at the next falling edge. A new setting reaches the output only after two synchronizer stages in the source domain and the end of the running output period, which is at most 256 ns here. The bench therefore waits 80 bus cycles after each write and then times whole periods of `sd_clk` edge to edge, with no cycle counting. It sweeps both revisions, both sources and all eight codes. The enable pulse is counted on source falling edges inside one measured period. Runt pulses are watched by timing every phase across a series of live source and ratio changes.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

  localparam int SD_CODE_W  = 3;
  localparam int SD_RATIO_W = 5;
  localparam int SD_HALF_W  = SD_RATIO_W - 1;

  // Divide ratio for a code; the all-ones code depends on the revision.
  function automatic logic [SD_RATIO_W-1:0] sd_ratio(
    input logic [SD_CODE_W-1:0] code,
    input logic                 late_rev
  );
    logic [SD_RATIO_W-1:0] r;
    if (code == '1)
      r = late_rev ? SD_RATIO_W'(1) : SD_RATIO_W'(2 ** (SD_CODE_W + 1));
    else
      r = (SD_RATIO_W'(code) + SD_RATIO_W'(1)) << 1;
    return r;
  endfunction

endpackage

// File: rtl/sdclk_ctrl_reg.sv
module sdclk_ctrl_reg #(
  parameter int DATA_W   = 32,
  parameter int GATE_BIT = 31,
  parameter int CODE_LSB = 28,
  parameter int CODE_W   = 3,
  parameter int SEL_BIT  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              run_q,
  output logic              pick_pll_q,
  output logic [CODE_W-1:0] code_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q      <= 1'b0;
      pick_pll_q <= 1'b0;
      code_q     <= '0;
    end else if (wr_en) begin
      run_q      <= wr_data[GATE_BIT];
      pick_pll_q <= wr_data[SEL_BIT];
      code_q     <= wr_data[CODE_LSB +: CODE_W];
    end
  end

  always_comb begin
    rd_data                      = '0;
    rd_data[GATE_BIT]            = run_q;
    rd_data[SEL_BIT]             = pick_pll_q;
    rd_data[CODE_LSB +: CODE_W]  = code_q;
  end

  logic unused_wr_bits;
  assign unused_wr_bits = ^wr_data;

endmodule

// File: rtl/sdclk_sync.sv
module sdclk_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) stage[i] <= '0;
        else     stage[i] <= stage[i-1];
      end
    end
  end

  assign q = stage[STAGES-1];

endmodule

// File: rtl/sdclk_clk_mux.sv
module sdclk_clk_mux (
  input  logic clk_a,
  input  logic clk_b,
  input  logic rst,
  input  logic pick_b,
  output logic clk_out,
  output logic a_on,
  output logic b_on
);

  logic a_arm, b_arm;

  // Each side arms only once the other side has been released.
  always_ff @(posedge clk_a) begin
    if (rst) a_arm <= 1'b1;
    else     a_arm <= !pick_b && !b_on;
  end

  always_ff @(negedge clk_a) begin
    if (rst) a_on <= 1'b1;
    else     a_on <= a_arm;
  end

  always_ff @(posedge clk_b) begin
    if (rst) b_arm <= 1'b0;
    else     b_arm <= pick_b && !a_on;
  end

  always_ff @(negedge clk_b) begin
    if (rst) b_on <= 1'b0;
    else     b_on <= b_arm;
  end

  assign clk_out = (clk_a & a_on) | (clk_b & b_on);

endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider
  import sdclk_pkg::*;
#(
  parameter int CODE_W  = SD_CODE_W,
  parameter int RATIO_W = SD_RATIO_W,
  parameter int HALF_W  = SD_HALF_W
) (
  input  logic              mclk,
  input  logic              rst,
  input  logic              run_s,
  input  logic              pick_s,
  input  logic [CODE_W-1:0] code_s,
  input  logic              late_s,
  output logic              pick_act,
  output logic              byp_act,
  output logic              sd_clk,
  output logic              clk_en
);

  logic [RATIO_W-1:0] nxt_ratio;
  logic [HALF_W-1:0]  half_q, cnt_q;
  logic               q_q, byp_on, phase_end, load_now;

  assign nxt_ratio = sd_ratio(code_s, late_s);
  assign phase_end = (cnt_q == half_q - HALF_W'(1));

  // New settings are accepted while stopped, every cycle in pass-through,
  // or at the falling edge that closes a divided period.
  assign load_now = !run_s || byp_act || (phase_end && q_q);

  always_ff @(posedge mclk) begin
    if (rst) begin
      pick_act <= 1'b0;
      byp_act  <= 1'b0;
      half_q   <= HALF_W'(1);
    end else if (load_now) begin
      pick_act <= pick_s;
      byp_act  <= (nxt_ratio == RATIO_W'(1));
      half_q   <= HALF_W'(nxt_ratio >> 1);
    end
  end

  always_ff @(posedge mclk) begin
    if (rst) begin
      cnt_q  <= '0;
      q_q    <= 1'b0;
      clk_en <= 1'b0;
    end else begin
      clk_en <= 1'b0;
      if (!run_s) begin
        cnt_q <= '0;
        q_q   <= 1'b0;
      end else if (byp_act) begin
        clk_en <= 1'b1;
      end else if (phase_end) begin
        cnt_q <= '0;
        q_q   <= !q_q;
        if (!q_q) clk_en <= 1'b1;
      end else begin
        cnt_q <= cnt_q + HALF_W'(1);
      end
    end
  end

  // Pass-through gate changes while the source is low.
  always_ff @(negedge mclk) begin
    if (rst) byp_on <= 1'b0;
    else     byp_on <= run_s && byp_act;
  end

  assign sd_clk = (mclk & byp_on) | q_q;

endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
  import sdclk_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int GATE_BIT    = 31,
  parameter int CODE_LSB    = 28,
  parameter int SEL_BIT     = 8,
  parameter int REV_LSB     = 16,
  parameter int REV_W       = 8,
  parameter int LATE_REV    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_bus,
  input  logic              clk_pll,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] chip_id,
  output logic              sd_clk,
  output logic              sd_clk_en
);

  localparam int CFG_W = SD_CODE_W + 3;

  logic                 run_q, pick_q, late_rev;
  logic [SD_CODE_W-1:0] code_q;
  logic [CFG_W-1:0]     cfg_s;
  logic                 run_sync, pick_sync, late_sync;
  logic [SD_CODE_W-1:0] code_sync;
  logic                 mclk, bus_on, pll_on, pick_act, byp_mode;

  assign late_rev = (chip_id[REV_LSB +: REV_W] >= REV_W'(LATE_REV));

  logic unused_id_bits;
  assign unused_id_bits = ^chip_id;

  sdclk_ctrl_reg #(
    .DATA_W(DATA_W), .GATE_BIT(GATE_BIT), .CODE_LSB(CODE_LSB),
    .CODE_W(SD_CODE_W), .SEL_BIT(SEL_BIT)
  ) u_reg (
    .clk(clk_bus), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .run_q(run_q), .pick_pll_q(pick_q), .code_q(code_q)
  );

  sdclk_sync #(.WIDTH(CFG_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(mclk), .rst(rst),
    .d({run_q, pick_q, late_rev, code_q}),
    .q(cfg_s)
  );

  assign {run_sync, pick_sync, late_sync, code_sync} = cfg_s;

  sdclk_clk_mux u_mux (
    .clk_a(clk_bus), .clk_b(clk_pll), .rst(rst), .pick_b(pick_act),
    .clk_out(mclk), .a_on(bus_on), .b_on(pll_on)
  );

  sdclk_divider u_div (
    .mclk(mclk), .rst(rst), .run_s(run_sync), .pick_s(pick_sync),
    .code_s(code_sync), .late_s(late_sync), .pick_act(pick_act),
    .byp_act(byp_mode), .sd_clk(sd_clk), .clk_en(sd_clk_en)
  );

endmodule

// File: rtl/sdclk_gen_chk.sv
module sdclk_gen_chk #(
  parameter int DATA_W   = 32,
  parameter int GATE_BIT = 31,
  parameter int CODE_LSB = 28,
  parameter int SEL_BIT  = 8
) (
  input logic              clk_bus,
  input logic              rst,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              mclk,
  input logic              bus_on,
  input logic              pll_on,
  input logic              run_sync,
  input logic              byp_mode,
  input logic              sd_clk_en
);

  localparam logic [DATA_W-1:0] KEEP =
    (DATA_W'(1) << GATE_BIT) | (DATA_W'(7) << CODE_LSB) | (DATA_W'(1) << SEL_BIT);

  a_r1_reset_clear: assert property (@(posedge clk_bus) disable iff (rst)
    $past(rst) |-> (rd_data == '0));

  a_r2_readback: assert property (@(posedge clk_bus) disable iff (rst)
    (!$past(rst) && $past(wr_en)) |-> (rd_data == ($past(wr_data) & KEEP)));

  a_r10_one_source: assert property (@(posedge clk_bus) disable iff (rst)
    $onehot0({bus_on, pll_on}));

  a_r7_gate_quiet: assert property (@(posedge mclk) disable iff (rst)
    !run_sync |=> !sd_clk_en);

  a_r8_single_pulse: assert property (@(posedge mclk) disable iff (rst)
    (sd_clk_en && !byp_mode && !$past(byp_mode)) |=> !sd_clk_en);

endmodule

bind sdclk_gen sdclk_gen_chk #(
  .DATA_W(DATA_W), .GATE_BIT(GATE_BIT), .CODE_LSB(CODE_LSB), .SEL_BIT(SEL_BIT)
) u_chk (
  .clk_bus(clk_bus), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .mclk(mclk), .bus_on(bus_on), .pll_on(pll_on),
  .run_sync(run_sync), .byp_mode(byp_mode), .sd_clk_en(sd_clk_en)
);

// File: tb/sdclk_gen_tb.sv
`timescale 1ns/1ps
module sdclk_gen_tb;

  localparam real CLK_PERIOD = 10.0;
  localparam real PLL_PERIOD = 16.0;
  localparam int  WATCHDOG   = 100000;
  localparam logic [31:0] KEEP = 32'hF000_0100;

  logic        clk_bus = 1'b0, clk_pll = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [31:0] wr_data = '0, chip_id = '0, rd_data;
  logic        sd_clk, sd_clk_en;

  int vecs = 0, errs = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2.0) clk_bus = ~clk_bus;
  always #(PLL_PERIOD / 2.0) clk_pll = ~clk_pll;

  sdclk_gen u_dut (
    .clk_bus(clk_bus), .clk_pll(clk_pll), .rst(rst), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .chip_id(chip_id),
    .sd_clk(sd_clk), .sd_clk_en(sd_clk_en)
  );

  // Enable pulse counting on falling edges of the source in use.
  bit counting = 1'b0, cur_pll = 1'b0;
  int en_cnt = 0;
  always @(negedge clk_bus) if (counting && !cur_pll && sd_clk_en) en_cnt++;
  always @(negedge clk_pll) if (counting &&  cur_pll && sd_clk_en) en_cnt++;

  // Phase-width monitor for runt detection.
  bit mon_on = 1'b0, seen_rise = 1'b0, seen_fall = 1'b0;
  realtime t_rise, t_fall;
  real min_hi = 1.0e9, min_lo = 1.0e9;
  always @(posedge sd_clk) begin
    if (mon_on && seen_fall && ($realtime - t_fall) < min_lo) min_lo = $realtime - t_fall;
    t_rise = $realtime; seen_rise = 1'b1;
  end
  always @(negedge sd_clk) begin
    if (mon_on && seen_rise && ($realtime - t_rise) < min_hi) min_hi = $realtime - t_rise;
    t_fall = $realtime; seen_fall = 1'b1;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input real act, input real exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: got %0.3f expected %0.3f", tag, what, act, exp);
    end
  endtask

  task automatic write_ctrl(input bit run, input bit pll, input int code);
    logic [31:0] w;
    w = (32'h0A5A_5E3F & ~KEEP) | (32'(run) << 31) | (32'(code) << 28) | (32'(pll) << 8);
    @(negedge clk_bus);
    wr_en = 1'b1; wr_data = w;
    @(negedge clk_bus);
    wr_en = 1'b0;
    check(rd_data == (w & KEEP), "R2", "readback", real'(rd_data), real'(w & KEEP));
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk_bus);
  endtask

  task automatic measure(input bit pll, input int ratio, input string tag);
    realtime t0, t1, t2;
    real src, exp_per, exp_hi;
    src     = pll ? PLL_PERIOD : CLK_PERIOD;
    exp_per = (ratio == 1) ? src : ratio * src;
    exp_hi  = (ratio == 1) ? src / 2.0 : (ratio / 2) * src;
    cur_pll = pll;
    @(posedge sd_clk); t0 = $realtime; en_cnt = 0; counting = 1'b1;
    @(negedge sd_clk); t1 = $realtime;
    @(posedge sd_clk); t2 = $realtime; counting = 1'b0;
    check((t2 - t0) > exp_per - 0.1 && (t2 - t0) < exp_per + 0.1, tag, "period", t2 - t0, exp_per);
    check((t1 - t0) > exp_hi - 0.1 && (t1 - t0) < exp_hi + 0.1, tag, "high time", t1 - t0, exp_hi);
    check(en_cnt == 1, "R8", "enable pulses per period", real'(en_cnt), 1.0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk_bus);
    if (!done) begin
      check(1'b0, "R1", "watchdog expired", 0.0, 1.0);
      finish_run();
    end
  end

  initial begin
    int hi_seen, en_seen;
    chip_id = 32'hA501_3C5A;
    repeat (10) @(negedge clk_bus);
    rst = 1'b0;
    @(negedge clk_bus);
    // R1: reset state
    check(rd_data == '0, "R1", "control word after reset", real'(rd_data), 0.0);
    hi_seen = 0; en_seen = 0;
    repeat (40) begin
      @(negedge clk_bus);
      if (sd_clk) hi_seen++;
      if (sd_clk_en) en_seen++;
    end
    check(hi_seen == 0, "R1", "sd_clk high samples", real'(hi_seen), 0.0);
    check(en_seen == 0, "R1", "enable samples", real'(en_seen), 0.0);

    // Sweep both revisions, both sources, all codes (R3..R6).
    for (int r = 0; r < 2; r++) begin
      chip_id = {8'hA5, (r == 0) ? 8'h01 : 8'h02, 16'h3C5A};
      for (int s = 0; s < 2; s++) begin
        for (int c = 0; c < 8; c++) begin
          int ratio;
          string tag;
          ratio = (c < 7) ? 2 * (c + 1) : ((r == 1) ? 1 : 16);
          tag = (c < 7) ? (s ? "R3,R4 pll" : "R3,R4 bus")
                        : ((r == 1) ? (s ? "R3,R6 pll" : "R3,R6 bus")
                                    : (s ? "R3,R5 pll" : "R3,R5 bus"));
          write_ctrl(1'b1, s[0], c);
          settle(80);
          measure(s[0], ratio, tag);
        end
      end
    end

    // R7: stop from pass-through on the PLL source.
    write_ctrl(1'b0, 1'b1, 7);
    settle(20);
    hi_seen = 0; en_seen = 0;
    repeat (100) begin
      @(negedge clk_bus);
      if (sd_clk) hi_seen++;
      if (sd_clk_en) en_seen++;
    end
    check(hi_seen == 0, "R7", "sd_clk high samples while stopped", real'(hi_seen), 0.0);
    check(en_seen == 0, "R7", "enable samples while stopped", real'(en_seen), 0.0);

    // R9, R10: live ratio and source changes on an early-revision part.
    chip_id = 32'hA501_3C5A;
    write_ctrl(1'b1, 1'b0, 0);
    settle(60);
    @(posedge sd_clk);
    mon_on = 1'b1;
    write_ctrl(1'b1, 1'b0, 6);  settle(90);
    write_ctrl(1'b1, 1'b1, 6);  settle(120);
    write_ctrl(1'b1, 1'b1, 0);  settle(90);
    write_ctrl(1'b1, 1'b0, 3);  settle(90);
    write_ctrl(1'b1, 1'b1, 7);  settle(150);
    write_ctrl(1'b1, 1'b0, 1);  settle(150);
    write_ctrl(1'b1, 1'b0, 0);  settle(60);
    mon_on = 1'b0;
    check(min_hi > CLK_PERIOD - 0.1, "R9,R10", "shortest high phase", min_hi, CLK_PERIOD);
    check(min_lo > CLK_PERIOD - 0.1, "R9,R10", "shortest low phase", min_lo, CLK_PERIOD);
    measure(1'b0, 2, "R9 final setting");

    finish_run();
  end

endmodule